// File: doc/BRIEF.md
# Tag-Matching Reservation Station Pool

This block is the waiting area that sits in front of one floating-point functional unit, for example the adder. Issue logic places an operation in a free slot. For each source operand it supplies either the value itself or the tag of the unit that will produce that value. Every occupied slot watches a result broadcast bus. The bus carries a result together with the tag of the slot or buffer it came from, not a destination address. When a broadcast tag equals a tag a slot is waiting on, the slot copies the data in.

A slot whose two operands are both present offers itself to the functional unit. When several slots are ready, the lowest-numbered one wins. Once the unit accepts a slot, that slot is marked as executing and is not offered again. The slot becomes free when its own result appears on the broadcast bus under its own tag. Each slot has a fixed tag of BASE_TAG plus its index, which gives 10, 11 and 12 by default. The pool raises `full` when every slot is occupied, so that issue can stall.

Top module: `rs_pool`

## Requirements
- R1: After reset every slot is free, `full` is low, `disp_valid` is low and `alloc_tag` reads BASE_TAG (10).
- R2: An accepted allocation (`alloc_valid` high while `full` is low) fills the lowest-numbered free slot. `alloc_tag` always shows the tag of that slot, which is BASE_TAG plus the slot index.
- R3: A source tag of zero means the supplied value is valid. A non-zero tag means the slot waits for that producer.
- R4: When `bcast_valid` is high and `bcast_tag` equals a non-zero tag that an occupied slot waits on, the slot stores `bcast_data` as that operand and clears the tag. This takes effect at the next clock edge.
- R5: An operand whose producer broadcasts in the same cycle as the allocation is captured from the bus, not lost.
- R6: A slot is offered on the dispatch port only when it is occupied, not executing, and has both tags zero. The port presents its op, both values and its tag.
- R7: Among ready slots, the lowest index is offered.
- R8: A slot accepted with `disp_valid` and `disp_ready` both high is marked executing and is never offered again.
- R9: A broadcast carrying an executing slot's own tag frees that slot.
- R10: `full` is high exactly when every slot is occupied. An allocation attempted while `full` is high changes nothing.
- R11: A broadcast with tag zero, or with a tag that no slot waits on, leaves every slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Issue request |
| alloc_op | input | OP_W | Operation code |
| alloc_vj | input | DATA_W | First operand value |
| alloc_qj | input | TAG_W | First operand producer tag, 0 = value valid |
| alloc_vk | input | DATA_W | Second operand value |
| alloc_qk | input | TAG_W | Second operand producer tag, 0 = value valid |
| alloc_tag | output | TAG_W | Tag of the slot the next allocation fills |
| full | output | 1 | No slot free |
| bcast_valid | input | 1 | Result broadcast present |
| bcast_tag | input | TAG_W | Source tag of the broadcast |
| bcast_data | input | DATA_W | Broadcast result |
| disp_valid | output | 1 | A ready slot is offered |
| disp_ready | input | 1 | Functional unit accepts the offer |
| disp_op | output | OP_W | Offered operation code |
| disp_vj | output | DATA_W | Offered first operand |
| disp_vk | output | DATA_W | Offered second operand |
| disp_tag | output | TAG_W | Tag of the offered slot |

## Verification
The bench aims at the cycles where two events overlap. In one, a producer broadcasts in the same cycle as an allocation; a design that looks only at stored tags would leave that operand waiting forever. In another, a free and a capture happen together. The bench holds several ready slots while the unit refuses them. A wrong priority would show up as the wrong tag on the dispatch port, and a missing executing mark would offer an accepted slot a second time. It also sends broadcasts with tag zero and with unused tags, and allocation attempts while the pool is full. A careless comparator would corrupt a waiting operand, and a missing full check would overwrite a busy slot; the bench sees either as a wrong value at dispatch.

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int ENTRIES  = 3,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int OP_W     = 4,
  parameter int BASE_TAG = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [OP_W-1:0]   alloc_op,
  input  logic [DATA_W-1:0] alloc_vj,
  input  logic [TAG_W-1:0]  alloc_qj,
  input  logic [DATA_W-1:0] alloc_vk,
  input  logic [TAG_W-1:0]  alloc_qk,
  output logic [TAG_W-1:0]  alloc_tag,
  output logic              full,
  input  logic              bcast_valid,
  input  logic [TAG_W-1:0]  bcast_tag,
  input  logic [DATA_W-1:0] bcast_data,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_vj,
  output logic [DATA_W-1:0] disp_vk,
  output logic [TAG_W-1:0]  disp_tag
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            busy_q, exec_q, ready;
  logic [ENTRIES-1:0][TAG_W-1:0] qj_q, qk_q;
  logic [OP_W-1:0]               op_q [ENTRIES];
  logic [DATA_W-1:0]             vj_q [ENTRIES];
  logic [DATA_W-1:0]             vk_q [ENTRIES];
  logic [IDX_W-1:0]              free_idx, sel_idx;
  logic                          alloc_fire, disp_fire;

  always_comb begin
    free_idx = '0;
    sel_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      ready[i] = busy_q[i] && !exec_q[i] && qj_q[i] == '0 && qk_q[i] == '0;
      if (!busy_q[i]) free_idx = IDX_W'(i);
      if (ready[i])   sel_idx  = IDX_W'(i);
    end
  end

  assign full       = &busy_q;
  assign alloc_fire = alloc_valid && !full;
  assign alloc_tag  = TAG_W'(BASE_TAG) + TAG_W'(free_idx);
  assign disp_valid = |ready;
  assign disp_fire  = disp_valid && disp_ready;
  assign disp_op    = op_q[sel_idx];
  assign disp_vj    = vj_q[sel_idx];
  assign disp_vk    = vk_q[sel_idx];
  assign disp_tag   = TAG_W'(BASE_TAG) + TAG_W'(sel_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      exec_q <= '0;
      qj_q   <= '0;
      qk_q   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        op_q[i] <= '0;
        vj_q[i] <= '0;
        vk_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (busy_q[i]) begin
          if (exec_q[i] && bcast_valid && bcast_tag == TAG_W'(BASE_TAG + i)) begin
            busy_q[i] <= 1'b0;
            exec_q[i] <= 1'b0;
          end else begin
            if (qj_q[i] != '0 && bcast_valid && bcast_tag == qj_q[i]) begin
              vj_q[i] <= bcast_data;
              qj_q[i] <= '0;
            end
            if (qk_q[i] != '0 && bcast_valid && bcast_tag == qk_q[i]) begin
              vk_q[i] <= bcast_data;
              qk_q[i] <= '0;
            end
            if (disp_fire && sel_idx == IDX_W'(i)) exec_q[i] <= 1'b1;
          end
        end else if (alloc_fire && free_idx == IDX_W'(i)) begin
          busy_q[i] <= 1'b1;
          exec_q[i] <= 1'b0;
          op_q[i]   <= alloc_op;
          if (alloc_qj != '0 && bcast_valid && bcast_tag == alloc_qj) begin
            vj_q[i] <= bcast_data;
            qj_q[i] <= '0;
          end else begin
            vj_q[i] <= alloc_vj;
            qj_q[i] <= alloc_qj;
          end
          if (alloc_qk != '0 && bcast_valid && bcast_tag == alloc_qk) begin
            vk_q[i] <= bcast_data;
            qk_q[i] <= '0;
          end else begin
            vk_q[i] <= alloc_vk;
            qk_q[i] <= alloc_qk;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int ENTRIES  = 3,
  parameter int TAG_W    = 4,
  parameter int BASE_TAG = 10
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ENTRIES-1:0]            busy_q,
  input logic [ENTRIES-1:0]            exec_q,
  input logic [ENTRIES-1:0][TAG_W-1:0] qj_q,
  input logic [ENTRIES-1:0][TAG_W-1:0] qk_q,
  input logic                          alloc_valid,
  input logic                          full,
  input logic                          bcast_valid,
  input logic [TAG_W-1:0]              bcast_tag,
  input logic                          disp_valid,
  input logic                          disp_ready,
  input logic [TAG_W-1:0]              disp_tag
);
  logic [ENTRIES-1:0] rdy;
  always_comb
    for (int j = 0; j < ENTRIES; j++)
      rdy[j] = busy_q[j] && !exec_q[j] && qj_q[j] == '0 && qk_q[j] == '0;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(BASE_TAG + i);
    localparam logic [ENTRIES-1:0] LOWER = ENTRIES'((1 << i) - 1);

    p_offer_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && disp_tag == MY_TAG |-> busy_q[i] && !exec_q[i] && qj_q[i] == '0 && qk_q[i] == '0);

    p_lowest_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && disp_tag == MY_TAG |-> (rdy & LOWER) == '0);

    p_writeback_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_valid && bcast_tag == MY_TAG && busy_q[i] && exec_q[i] |=> !busy_q[i]);

    p_exec_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exec_q[i] && !(bcast_valid && bcast_tag == MY_TAG) |=> exec_q[i]);
  end

  p_no_reoffer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_ready |=> !(disp_valid && disp_tag == $past(disp_tag)));

  p_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full && alloc_valid |=> $countones(busy_q) <= $countones($past(busy_q)));
endmodule

bind rs_pool rs_pool_chk #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .BASE_TAG(BASE_TAG)) u_chk (.*);

// File: tb/test_rs_pool.sv
module test_rs_pool;
  localparam int N = 3, DW = 64, TW = 4, OW = 4, BT = 10;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, bcast_valid = 0, disp_ready = 0;
  logic [OW-1:0] alloc_op = 0;
  logic [DW-1:0] alloc_vj = 0, alloc_vk = 0, bcast_data = 0;
  logic [TW-1:0] alloc_qj = 0, alloc_qk = 0, bcast_tag = 0;
  logic [TW-1:0] alloc_tag, disp_tag;
  logic full, disp_valid;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_vj, disp_vk;

  always #10 clk = ~clk;

  rs_pool i_rs_pool (.*);

  int checks = 0, fails = 0;
  string cur = "R1";
  bit done = 0;

  bit m_busy [N], m_exec [N];
  int m_qj [N], m_qk [N], m_op [N];
  logic [DW-1:0] m_vj [N], m_vk [N];

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int m_free();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic int m_sel();
    for (int i = 0; i < N; i++)
      if (m_busy[i] && !m_exec[i] && m_qj[i] == 0 && m_qk[i] == 0) return i;
    return -1;
  endfunction

  task automatic model_step();
    bit o_busy [N], o_exec [N];
    int f, s;
    int bt;
    f = m_free();
    s = m_sel();
    bt = int'(bcast_tag);
    o_busy = m_busy;
    o_exec = m_exec;
    for (int i = 0; i < N; i++) begin
      if (!o_busy[i]) continue;
      if (o_exec[i] && bcast_valid && bt == BT + i) begin
        m_busy[i] = 0;
        m_exec[i] = 0;
        continue;
      end
      if (bcast_valid && m_qj[i] != 0 && m_qj[i] == bt) begin m_vj[i] = bcast_data; m_qj[i] = 0; end
      if (bcast_valid && m_qk[i] != 0 && m_qk[i] == bt) begin m_vk[i] = bcast_data; m_qk[i] = 0; end
    end
    if (s >= 0 && disp_ready) m_exec[s] = 1;
    if (alloc_valid && f >= 0) begin
      m_busy[f] = 1; m_exec[f] = 0; m_op[f] = int'(alloc_op);
      m_vj[f] = alloc_vj; m_qj[f] = int'(alloc_qj);
      m_vk[f] = alloc_vk; m_qk[f] = int'(alloc_qk);
      if (bcast_valid && m_qj[f] != 0 && m_qj[f] == bt) begin m_vj[f] = bcast_data; m_qj[f] = 0; end
      if (bcast_valid && m_qk[f] != 0 && m_qk[f] == bt) begin m_vk[f] = bcast_data; m_qk[f] = 0; end
    end
  endtask

  task automatic compare();
    int f, s;
    f = m_free();
    s = m_sel();
    chk(full == (f < 0), "R10", "full", DW'(full), DW'(f < 0));
    if (f >= 0) chk(alloc_tag == TW'(BT + f), "R2", "alloc_tag", DW'(alloc_tag), DW'(BT + f));
    chk(disp_valid == (s >= 0), cur, "disp_valid", DW'(disp_valid), DW'(s >= 0));
    if (s >= 0 && disp_valid) begin
      chk(disp_tag == TW'(BT + s), "R7", "disp_tag", DW'(disp_tag), DW'(BT + s));
      chk(disp_op == OW'(m_op[s]), cur, "disp_op", DW'(disp_op), DW'(m_op[s]));
      chk(disp_vj == m_vj[s], cur, "disp_vj", disp_vj, m_vj[s]);
      chk(disp_vk == m_vk[s], cur, "disp_vk", disp_vk, m_vk[s]);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    alloc_valid = 0; bcast_valid = 0; disp_ready = 0;
  endtask

  task automatic alloc(int op, logic [DW-1:0] vj, int qj, logic [DW-1:0] vk, int qk);
    alloc_valid = 1; alloc_op = OW'(op);
    alloc_vj = vj; alloc_qj = TW'(qj); alloc_vk = vk; alloc_qk = TW'(qk);
  endtask

  task automatic bcast(int tag, logic [DW-1:0] d);
    bcast_valid = 1; bcast_tag = TW'(tag); bcast_data = d;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 0; m_exec[i] = 0; m_qj[i] = 0; m_qk[i] = 0; m_op[i] = 0;
      m_vj[i] = 0; m_vk[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!full && !disp_valid, "R1", "idle after reset", DW'({full, disp_valid}), 0);
    chk(alloc_tag == TW'(BT), "R1", "first alloc_tag", DW'(alloc_tag), DW'(BT));

    cur = "R2"; alloc(1, 64'h0, 3, 64'h2222, 0); cyc();
    chk(alloc_tag == TW'(BT + 1), "R2", "next slot tag", DW'(alloc_tag), DW'(BT + 1));
    cur = "R3"; alloc(2, 64'hA1, 0, 64'hB1, 0); cyc();
    chk(disp_valid && disp_tag == TW'(BT + 1), "R3", "ready slot offered", DW'(disp_tag), DW'(BT + 1));

    cur = "R4"; bcast(3, 64'hDEAD_BEEF_0000_0003); cyc();
    chk(disp_tag == TW'(BT) && disp_vj == 64'hDEAD_BEEF_0000_0003, "R4", "captured operand", disp_vj, 64'hDEAD_BEEF_0000_0003);
    cur = "R7"; cyc();
    chk(disp_tag == TW'(BT), "R7", "lowest ready wins", DW'(disp_tag), DW'(BT));

    cur = "R8"; disp_ready = 1; cyc();
    chk(disp_tag == TW'(BT + 1), "R8", "accepted slot not re-offered", DW'(disp_tag), DW'(BT + 1));
    disp_ready = 1; cyc();
    chk(!disp_valid, "R8", "nothing left to offer", DW'(disp_valid), 0);

    cur = "R9"; bcast(BT, 64'h1234); cyc();
    chk(alloc_tag == TW'(BT), "R9", "slot freed by own tag", DW'(alloc_tag), DW'(BT));

    cur = "R5"; alloc(5, 64'h0, BT + 1, 64'h77, 0); bcast(BT + 1, 64'h5555_AAAA); cyc();
    chk(disp_valid && disp_vj == 64'h5555_AAAA, "R5", "same-cycle capture", disp_vj, 64'h5555_AAAA);

    cur = "R10"; alloc(6, 64'h0, 7, 64'h66, 0); cyc();
    alloc(7, 64'h71, 0, 64'h0, 7); cyc();
    chk(full, "R10", "full when all busy", DW'(full), 1);
    alloc(9, 64'hFFFF, 0, 64'hFFFF, 0); cyc();
    chk(full && disp_tag == TW'(BT) && disp_op == OW'(5), "R10", "alloc while full ignored", DW'(disp_op), 5);

    cur = "R11"; bcast(0, 64'hBAD0); cyc();
    bcast(9, 64'hBAD9); cyc();
    chk(disp_tag == TW'(BT), "R11", "unmatched broadcasts ignored", DW'(disp_tag), DW'(BT));

    cur = "R9"; disp_ready = 1; cyc();
    bcast(BT, 64'h0); cyc();
    chk(!full && alloc_tag == TW'(BT), "R9", "slot 10 freed", DW'(alloc_tag), DW'(BT));

    cur = "R4"; bcast(7, 64'hC0FFEE); cyc();
    chk(disp_tag == TW'(BT + 1) && disp_vj == 64'hC0FFEE, "R4", "both waiters capture", disp_vj, 64'hC0FFEE);
    disp_ready = 1; cyc();
    chk(disp_tag == TW'(BT + 2) && disp_vk == 64'hC0FFEE, "R7", "next slot after accept", disp_vk, 64'hC0FFEE);
    cyc();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule